// File: doc/BRIEF.md
# Video Crosspoint Matrix Control Register Bank

This block is the digital control side of a 16-output, 16-input video crosspoint. A serial port shifts configuration bits, MSB first, into a 96-bit holding register whose top bit leaves on a serial output, so several devices can share one bus. An update strobe then moves the holding contents into a shadow register and into the active control latches. The active latches drive, for every output, a 4-bit input select, a gain bit and a buffer-enable bit. A short 16-bit word can instead rewrite a single output's field. The kind of load is decided by the number of bits shifted since the last strobe.

A control state machine with three states governs reset. POR_HOLD is entered while the supply-good flag is low and held for a parameterised count of cycles after it rises. HALTED is entered whenever the synchronised external reset or the over-temperature flag is active. RUNNING is the normal state. The transitions are as follows. POR_HOLD goes to RUNNING when the count expires with no request, or to HALTED when it expires with one. RUNNING goes to HALTED when a request appears. HALTED goes to RUNNING when the request clears. In any state but RUNNING every enable bit is forced low, while selects, gains and the shadow register are kept. A bare strobe, with no bits shifted, copies the shadow back and so restores the earlier setup.

Each output also has an active-low overlay key. When the key is low, that output takes the fill source instead of the matrix selection. The key never alters the stored settings.

Top module: `xbar_ctl`

## Requirements
- R1: While `por_ok` is low every output of the matrix is 0 and `rst_drv_n` is 0. After `por_ok` rises, `rst_drv_n` stays 0 for exactly POR_HOLD rising edges (default 8) and goes to 1 after the POR_HOLD-th edge, unless a reset request is active.
- R2: While `sen` is 1, each rising edge shifts `sdi` into bit 0 of the 96-bit holding register and moves the bits up. `sdo` always shows bit 95 and does not change on edges where `sen` is 0. A word shifted in first therefore appears on `sdo`, MSB first, while the next 96 bits are shifted.
- R3: An update strobe after a shift count that is neither 0 nor an individual word copies the holding register into both shadow and active latches. Output k uses bits [6k+5:6k]: select in [6k+5:6k+2], gain in [6k+1], enable in [6k].
- R4: An update strobe after exactly 16 shifted bits with holding bit 15 = 1 is an individual write. Bits [14:11] give the output address and bits [5:0] the new field. Only that output's field changes, in both shadow and active latches.
- R5: Reset from any source (external low, over-temperature high, power-on hold) clears only the active enable bits. Selects and gains stay unchanged.
- R6: `ext_rst_n` low or `ot_flag` high drives `rst_drv_n` to 0 within 3 rising edges, and it stays 0 while the request lasts.
- R7: After reset is released, all enables stay 0 until an update strobe. A bare strobe (0 bits shifted since the last strobe) copies the shadow into the active latches, enables included.
- R8: An update strobe that falls while reset is active still loads the shadow, selects and gains, but the enables stay 0.
- R9: `fill_o[k]` is the inverse of `key_n[k]`, combinationally. The keys never change `sel_o`, `gain_o` or `oe_o`.
- R10: `sel_o` and `gain_o` change only on the edge that follows an update strobe. Shifting alone does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por_ok | input | 1 | Supply-good flag; low clears all state asynchronously |
| ext_rst_n | input | 1 | External active-low reset request |
| ot_flag | input | 1 | Over-temperature flag, high requests reset |
| sdi | input | 1 | Serial configuration data |
| sen | input | 1 | Shift enable |
| upd | input | 1 | Update strobe, one cycle |
| key_n | input | 16 | Per-output overlay key, low selects fill |
| sdo | output | 1 | Serial data to the next device in the chain |
| sel_o | output | 64 | Per-output 4-bit input select, output k in [4k+3:4k] |
| gain_o | output | 16 | Per-output gain bit |
| oe_o | output | 16 | Per-output buffer enable |
| fill_o | output | 16 | Per-output fill-source select |
| rst_drv_n | output | 1 | Low while the block is not RUNNING |

## Verification
The update strobe and a reset request can act in the same cycle. The defined outcome is that the data lands in the shadow register and in the select and gain latches, while every enable stays at zero. The bench provokes this by shifting a new word and pulsing the strobe while the external reset is held low. It then checks three things: the new selects are visible with all enables off, the enables are still off after release, and a bare strobe finally restores the word with its enables. The bench also times when the enables fall against the synchronised request, and checks that the keys leave the latched settings alone.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_HALT = 2'd1,
        ST_RUN  = 2'd2
    } ctl_state_t;

    typedef enum logic [1:0] {
        LD_RESTORE = 2'd0,
        LD_SINGLE  = 2'd1,
        LD_FULL    = 2'd2
    } load_kind_t;
endpackage

// File: rtl/xbar_rst_fsm.sv
module xbar_rst_fsm
    import xbar_pkg::*;
#(
    parameter int POR_HOLD = 8
) (
    input  logic clk,
    input  logic por_ok,
    input  logic ext_rst_n,
    input  logic ot_flag,
    output logic run,
    output logic run_next
);
    localparam int PCW = (POR_HOLD < 2) ? 1 : $clog2(POR_HOLD + 1);

    ctl_state_t     st_q, st_d;
    logic [1:0]     req_sync;
    logic [PCW-1:0] por_cnt;
    logic           req;
    logic           raw_req;

    assign raw_req = ~ext_rst_n | ot_flag;
    assign req     = req_sync[1];

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) req_sync <= 2'b11;
        else         req_sync <= {req_sync[0], raw_req};
    end

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok)
            por_cnt <= '0;
        else if (st_q == ST_POR && por_cnt != PCW'(POR_HOLD - 1))
            por_cnt <= por_cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) st_q <= ST_POR;
        else         st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_POR:  if (por_cnt == PCW'(POR_HOLD - 1)) st_d = req ? ST_HALT : ST_RUN;
            ST_HALT: if (!req) st_d = ST_RUN;
            ST_RUN:  if (req)  st_d = ST_HALT;
            default: st_d = ST_POR;
        endcase
    end

    // outputs
    always_comb begin
        run      = (st_q == ST_RUN);
        run_next = (st_d == ST_RUN);
    end
endmodule

// File: rtl/xbar_shift.sv
module xbar_shift
    import xbar_pkg::*;
#(
    parameter int WORD_W   = 96,
    parameter int SINGLE_W = 16
) (
    input  logic              clk,
    input  logic              por_ok,
    input  logic              sen,
    input  logic              sdi,
    input  logic              upd,
    output logic [WORD_W-1:0] sreg,
    output logic              sdo,
    output load_kind_t        kind
);
    localparam int CW = $clog2(WORD_W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok)  sreg <= '0;
        else if (sen) sreg <= {sreg[WORD_W-2:0], sdi};
    end

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok)
            cnt <= '0;
        else if (upd)
            cnt <= sen ? CW'(1) : '0;
        else if (sen && cnt != CW'(WORD_W))
            cnt <= cnt + 1'b1;
    end

    assign sdo = sreg[WORD_W-1];

    always_comb begin
        if (cnt == '0)
            kind = LD_RESTORE;
        else if (cnt == CW'(SINGLE_W) && sreg[SINGLE_W-1])
            kind = LD_SINGLE;
        else
            kind = LD_FULL;
    end
endmodule

// File: rtl/xbar_latch.sv
module xbar_latch
    import xbar_pkg::*;
#(
    parameter int N_OUT    = 16,
    parameter int SEL_W    = 4,
    parameter int SINGLE_W = 16,
    localparam int FW      = SEL_W + 2,
    localparam int WORD_W  = N_OUT * FW
) (
    input  logic              clk,
    input  logic              por_ok,
    input  logic              upd,
    input  load_kind_t        kind,
    input  logic [WORD_W-1:0] sreg,
    input  logic              run_next,
    output logic [WORD_W-1:0] act
);
    localparam int AW = (N_OUT < 2) ? 1 : $clog2(N_OUT);

    logic [WORD_W-1:0] shd_q, shd_d, act_d;
    logic [AW-1:0]     addr;
    logic [FW-1:0]     fld;

    assign addr = sreg[SINGLE_W-2 -: AW];
    assign fld  = sreg[FW-1:0];

    always_comb begin
        shd_d = shd_q;
        act_d = act;
        if (upd) begin
            unique case (kind)
                LD_RESTORE: act_d = shd_q;
                LD_SINGLE: begin
                    if (int'(addr) < N_OUT) begin
                        shd_d[addr*FW +: FW] = fld;
                        act_d[addr*FW +: FW] = fld;
                    end
                end
                default: begin
                    shd_d = sreg;
                    act_d = sreg;
                end
            endcase
        end
        if (!run_next) begin
            for (int i = 0; i < N_OUT; i++) act_d[i*FW] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) begin
            shd_q <= '0;
            act   <= '0;
        end else begin
            shd_q <= shd_d;
            act   <= act_d;
        end
    end
endmodule

// File: rtl/xbar_ctl.sv
module xbar_ctl
    import xbar_pkg::*;
#(
    parameter int N_OUT    = 16,
    parameter int SEL_W    = 4,
    parameter int SINGLE_W = 16,
    parameter int POR_HOLD = 8
) (
    input  logic                   clk,
    input  logic                   por_ok,
    input  logic                   ext_rst_n,
    input  logic                   ot_flag,
    input  logic                   sdi,
    input  logic                   sen,
    input  logic                   upd,
    input  logic [N_OUT-1:0]       key_n,
    output logic                   sdo,
    output logic [N_OUT*SEL_W-1:0] sel_o,
    output logic [N_OUT-1:0]       gain_o,
    output logic [N_OUT-1:0]       oe_o,
    output logic [N_OUT-1:0]       fill_o,
    output logic                   rst_drv_n
);
    localparam int FW     = SEL_W + 2;
    localparam int WORD_W = N_OUT * FW;

    logic              run, run_next;
    logic [WORD_W-1:0] sreg, act;
    load_kind_t        kind;

    xbar_rst_fsm #(.POR_HOLD(POR_HOLD)) u_fsm (
        .clk(clk), .por_ok(por_ok), .ext_rst_n(ext_rst_n), .ot_flag(ot_flag),
        .run(run), .run_next(run_next)
    );

    xbar_shift #(.WORD_W(WORD_W), .SINGLE_W(SINGLE_W)) u_shift (
        .clk(clk), .por_ok(por_ok), .sen(sen), .sdi(sdi), .upd(upd),
        .sreg(sreg), .sdo(sdo), .kind(kind)
    );

    xbar_latch #(.N_OUT(N_OUT), .SEL_W(SEL_W), .SINGLE_W(SINGLE_W)) u_latch (
        .clk(clk), .por_ok(por_ok), .upd(upd), .kind(kind), .sreg(sreg),
        .run_next(run_next), .act(act)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assign sel_o[k*SEL_W +: SEL_W] = act[k*FW+2 +: SEL_W];
        assign gain_o[k]               = act[k*FW+1];
        assign oe_o[k]                 = act[k*FW];
        assign fill_o[k]               = ~key_n[k];
    end

    assign rst_drv_n = run;
endmodule

// File: rtl/xbar_ctl_chk.sv
module xbar_ctl_chk #(
    parameter int N_OUT = 16,
    parameter int SEL_W = 4
) (
    input logic                   clk,
    input logic                   por_ok,
    input logic                   ext_rst_n,
    input logic                   upd,
    input logic                   sen,
    input logic                   sdo,
    input logic                   run,
    input logic [N_OUT*SEL_W-1:0] sel_o,
    input logic [N_OUT-1:0]       gain_o,
    input logic [N_OUT-1:0]       oe_o
);
    AST_OE_OFF_HALTED: assert property (@(posedge clk) disable iff (!por_ok)
        !run |-> oe_o == '0); // R5

    AST_OE_RISE_NEEDS_UPD: assert property (@(posedge clk) disable iff (!por_ok)
        (|(oe_o & ~$past(oe_o))) |-> $past(upd)); // R7

    AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!por_ok)
        !$past(upd) |-> ($stable(sel_o) && $stable(gain_o))); // R10

    AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!por_ok)
        !$past(sen) |-> $stable(sdo)); // R2

    AST_EXT_HALTS: assert property (@(posedge clk) disable iff (!por_ok)
        (!$past(ext_rst_n, 1) && !$past(ext_rst_n, 2) && !$past(ext_rst_n, 3)) |-> !run); // R6
endmodule

bind xbar_ctl xbar_ctl_chk #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .por_ok(por_ok), .ext_rst_n(ext_rst_n), .upd(upd), .sen(sen),
    .sdo(sdo), .run(run), .sel_o(sel_o), .gain_o(gain_o), .oe_o(oe_o)
);

// File: tb/tb_xbar_ctl.sv
module tb_xbar_ctl;
    localparam int N_OUT = 16, SEL_W = 4, FW = 6, WW = 96, SW = 16, POR_HOLD = 8;

    logic clk = 0, por_ok = 0, ext_rst_n = 1, ot_flag = 0, sdi = 0, sen = 0, upd = 0;
    logic [N_OUT-1:0] key_n = '1;
    logic sdo, rst_drv_n;
    logic [N_OUT*SEL_W-1:0] sel_o;
    logic [N_OUT-1:0] gain_o, oe_o, fill_o;

    xbar_ctl dut (.clk(clk), .por_ok(por_ok), .ext_rst_n(ext_rst_n), .ot_flag(ot_flag),
        .sdi(sdi), .sen(sen), .upd(upd), .key_n(key_n), .sdo(sdo), .sel_o(sel_o),
        .gain_o(gain_o), .oe_o(oe_o), .fill_o(fill_o), .rst_drv_n(rst_drv_n));

    always #5 clk = ~clk;

    int errs = 0, checks = 0;
    bit done = 0;
    logic [WW-1:0] m_sreg = '0, m_shd = '0, m_act = '0;
    int m_cnt = 0;
    bit m_run = 0;

    task automatic chk(input string req, input string what, input logic [WW-1:0] got, input logic [WW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
        end
    endtask

    function automatic logic [WW-1:0] outs();
        logic [WW-1:0] v;
        for (int i = 0; i < N_OUT; i++) v[i*FW +: FW] = {sel_o[i*SEL_W +: SEL_W], gain_o[i], oe_o[i]};
        return v;
    endfunction

    task automatic check_outs(input string req);
        chk(req, "matrix", outs(), m_act);
    endtask

    function automatic logic [WW-1:0] no_en(input logic [WW-1:0] v);
        for (int i = 0; i < N_OUT; i++) v[i*FW] = 1'b0;
        return v;
    endfunction

    task automatic drive_bit(input logic b);
        @(negedge clk);
        sdi = b; sen = 1;
        m_sreg = {m_sreg[WW-2:0], b};
        if (m_cnt < WW) m_cnt++;
    endtask

    task automatic shift_bits(input logic [WW-1:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) drive_bit(v[i]);
        @(negedge clk) sen = 0;
    endtask

    task automatic do_upd();
        logic [3:0] a;
        @(negedge clk) upd = 1;
        if (m_cnt == 0) m_act = m_shd;
        else if (m_cnt == SW && m_sreg[SW-1]) begin
            a = m_sreg[14:11];
            m_shd[a*FW +: FW] = m_sreg[5:0];
            m_act[a*FW +: FW] = m_sreg[5:0];
        end else begin
            m_shd = m_sreg; m_act = m_sreg;
        end
        if (!m_run) m_act = no_en(m_act);
        m_cnt = 0;
        @(negedge clk) upd = 0;
    endtask

    task automatic set_req(input logic ext_n, input logic ot);
        @(negedge clk);
        ext_rst_n = ext_n; ot_flag = ot;
        repeat (4) @(negedge clk);
        m_run = ext_n && !ot;
        if (!m_run) m_act = no_en(m_act);
    endtask

    function automatic logic [WW-1:0] rnd_word();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    task automatic single(input logic [3:0] a, input logic [5:0] f);
        logic [WW-1:0] v = '0;
        v[15:0] = {1'b1, a, 5'($urandom()), f};
        shift_bits(v, SW);
        do_upd();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] a_w, b_w, c_w, keep;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R1", "matrix in power-on", outs(), '0);
        chk("R1", "rst_drv_n in power-on", WW'(rst_drv_n), '0);
        por_ok = 1;
        for (int k = 1; k <= POR_HOLD; k++) begin
            @(negedge clk);
            chk("R1", $sformatf("rst_drv_n edge %0d", k), WW'(rst_drv_n), WW'(k == POR_HOLD));
        end
        m_run = 1;

        // constrained random mix of load kinds and keys
        for (int it = 0; it < 60; it++) begin
            int r = $urandom() % 5;
            case (r)
                0: begin shift_bits(rnd_word(), WW); do_upd(); check_outs("R3 full"); end
                1: begin single(4'($urandom()), 6'($urandom())); check_outs("R4 single"); end
                2: begin do_upd(); check_outs("R7 bare"); end
                3: begin
                    logic [WW-1:0] v = rnd_word();
                    v[15] = 1'b0;
                    shift_bits(v, SW); do_upd(); check_outs("R3 short mode0");
                end
                default: begin
                    key_n = 16'($urandom());
                    @(negedge clk);
                    chk("R9", "fill", WW'(fill_o), WW'(~key_n));
                    check_outs("R9 key leaves matrix");
                end
            endcase
        end

        // shifting alone does not touch the latches
        shift_bits(rnd_word(), 50);
        check_outs("R10 shift only");
        do_upd(); check_outs("R3 partial count");

        // daisy chain: first word exits on sdo MSB first
        a_w = rnd_word(); b_w = rnd_word();
        shift_bits(a_w, WW);
        for (int j = 0; j < WW; j++) begin
            @(negedge clk);
            if (j % 8 == 0) chk("R2", $sformatf("sdo bit %0d", j), WW'(sdo), WW'(a_w[WW-1-j]));
            sdi = b_w[WW-1-j]; sen = 1;
            m_sreg = {m_sreg[WW-2:0], b_w[WW-1-j]};
            if (m_cnt < WW) m_cnt++;
        end
        @(negedge clk) sen = 0;
        do_upd(); check_outs("R2 last word stays");
        repeat (3) @(negedge clk);
        chk("R2", "sdo idle", WW'(sdo), WW'(b_w[WW-1]));

        // external reset: enables only, then release and bare restore
        keep = rnd_word() | {N_OUT{6'b000001}};
        shift_bits(keep, WW); do_upd(); check_outs("R3 enables set");
        set_req(0, 0);
        chk("R6", "rst_drv_n ext", WW'(rst_drv_n), '0);
        check_outs("R5 ext clears enables only");
        set_req(1, 0);
        chk("R6", "rst_drv_n released", WW'(rst_drv_n), 1);
        check_outs("R7 stay off after release");
        do_upd();
        chk("R7", "bare restore", outs(), keep);

        // update during reset
        set_req(0, 0);
        c_w = rnd_word() | {N_OUT{6'b000001}};
        shift_bits(c_w, WW); do_upd();
        chk("R8", "load in reset", outs(), no_en(c_w));
        set_req(1, 0);
        check_outs("R8 off after release");
        do_upd();
        chk("R8", "restore after reset load", outs(), c_w);

        // thermal flag, then single-output re-enable
        set_req(1, 1);
        chk("R6", "rst_drv_n thermal", WW'(rst_drv_n), '0);
        check_outs("R5 thermal");
        set_req(1, 0);
        check_outs("R7 after thermal");
        single(4'd9, 6'b101011);
        check_outs("R4 single enables one");
        chk("R4", "only oe9", WW'(oe_o), WW'(16'h0200));

        // power loss clears everything at once
        @(negedge clk) por_ok = 0;
        #1;
        chk("R1", "matrix on power loss", outs(), '0);
        chk("R1", "rst_drv_n on power loss", WW'(rst_drv_n), '0);

        done = 1;
        summary();
        $finish;
    end
endmodule